// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Core

This core is the slave side of a three-wire serial memory: a chip select, a serial clock and a data input, plus a data output with its own output enable. Behind the interface sits a 4096-bit register array that stands in for the nonvolatile cells. A strap input picks the organization: 256 words of 16 bits or 512 bytes of 8 bits. A host raises chip select, clocks in a start bit, a two-bit opcode and an address, and the core then reads, writes, erases, fills or clears the whole array, or sets or clears a write-enable latch.

All pins are sampled in the system clock domain. A serial clock rising edge is recognised one system clock after it appears on the pin. Programming takes a parameterised number of system clocks, and during that time the host can poll ready or busy on the data output. Charge pump behaviour and real cell timing are not modelled.

Top module: `uwire_eeprom`

## Requirements
- R1: Bits on `di` are taken on rising edges of `sck` while `cs` is high. An instruction is a start bit of 1, an opcode (MSB first), then the address (MSB first). The address is 8 bits when `org16`=1 and 9 bits when `org16`=0, so the instruction is 11 or 12 bits long.
- R2: While `cs` is high and no instruction is in progress, 0 bits on `di` are skipped until the first 1, which is the start bit.
- R3: Opcode 10 is a read. On the edge that takes the last address bit, the core drives a dummy 0. Each of the next 16 edges (`org16`=1) or 8 edges (`org16`=0) drives one data bit, MSB first. The edge after that turns `do_oe` off.
- R4: Opcode 01 is write, 11 is erase, and 00 decodes the two top address bits: 11 enable, 00 disable, 01 write-all, 10 erase-all. Write, erase, write-all and erase-all change nothing and start no busy period unless enable was issued after reset or after the last disable.
- R5: In byte mode, byte address A maps to word A>>1. A[0]=1 selects bits 15:8 of that word and A[0]=0 selects bits 7:0. Write data follows the address, MSB first: 16 bits in word mode, 8 bits in byte mode.
- R6: Erase sets the addressed word or byte to all ones. Erase-all sets the whole array to all ones.
- R7: Write-all stores its data in every word. In byte mode it stores the data in every byte.
- R8: An enabled write, erase, write-all or erase-all takes effect when `cs` falls after the complete instruction and data. That fall starts a busy period of WRITE_CYCLES clocks. While `cs` is high afterwards, and until a start bit is accepted, `do_oe`=1 and `do_o` is 0 while busy and 1 when ready.
- R9: During a busy period, serial clock edges are ignored and no instruction starts.
- R10: After reset the array holds all ones and writes are disabled. `do_oe` is 0 whenever `cs` is low, and also whenever `cs` is high with neither read data nor status being shown.
- R11: Taking `cs` low before an instruction and its data are complete aborts it. Nothing is changed and no busy period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| org16 | input | 1 | Organization strap: 1 = 16-bit words, 0 = bytes |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock |
| di | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out value |
| do_oe | output | 1 | Output enable for `do_o`; 0 means high impedance |

## Verification
Reads are checked bit by bit, dummy zero included, against a model in the bench. They are run after single-location writes and erases, after whole-array fills and clears, and in both organizations. A byte written in byte mode and read back as a word shows that the byte-to-word mapping is right. Writes issued while disabled, partly sent instructions, leading zeros before the start bit, and instructions sent during a busy period each have one cause of error that the next read or the status output exposes. Status polling is sampled early and late in the busy window to tell busy apart from ready.

// File: rtl/uwire_eeprom.sv
module uwire_eeprom #(
  parameter int MEM_BITS     = 4096,
  parameter int WRITE_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic org16,
  input  logic cs,
  input  logic sck,
  input  logic di,
  output logic do_o,
  output logic do_oe
);
  localparam int WORDS = MEM_BITS / 16;
  localparam int AW    = $clog2(WORDS);
  localparam int HW    = AW + 3;
  localparam int BCW   = $clog2(WRITE_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_WDAT, S_RD, S_ARM, S_DONE} st_t;
  typedef enum logic [1:0] {P_WR, P_ER, P_WRAL, P_ERAL} pend_t;

  logic [15:0]    mem [WORDS];
  logic           sck_q, cs_q, wen, stat, rd_oe, do_r;
  st_t            st;
  pend_t          pend;
  logic [HW-2:0]  hdr;
  logic [15:0]    dat, rd_sr;
  logic [4:0]     cnt;
  logic [BCW-1:0] bcnt;

  wire sck_rise = cs & sck & ~sck_q;
  wire cs_fall  = cs_q & ~cs;
  wire busy     = bcnt != '0;
  wire go       = cs_fall && st == S_ARM && wen;

  wire [4:0]    hlen = org16 ? 5'(AW + 2) : 5'(AW + 3);
  wire [4:0]    dlen = org16 ? 5'd16 : 5'd8;
  wire [HW-1:0] nh   = {hdr, di};
  wire [1:0]    op_n  = org16 ? nh[AW+1:AW] : nh[AW+2:AW+1];
  wire [1:0]    sub_n = org16 ? nh[AW-1:AW-2] : nh[AW:AW-1];
  wire [AW:0]   a_now  = org16 ? {1'b0, nh[AW-1:0]} : nh[AW:0];
  wire [AW:0]   a_held = org16 ? {1'b0, hdr[AW-1:0]} : hdr[AW:0];
  wire [AW-1:0] w_now  = org16 ? a_now[AW-1:0] : a_now[AW:1];
  wire [AW-1:0] w_held = org16 ? a_held[AW-1:0] : a_held[AW:1];
  wire [15:0]   rword  = mem[w_now];
  wire [15:0]   rdata  = org16 ? rword : {(a_now[0] ? rword[15:8] : rword[7:0]), 8'h00};

  assign do_oe = cs & (rd_oe | stat);
  assign do_o  = rd_oe ? do_r : ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bcnt <= '0;
    else if (go) bcnt <= BCW'(WRITE_CYCLES);
    else if (busy) bcnt <= bcnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      pend  <= P_WR;
      hdr   <= '0;
      dat   <= '0;
      rd_sr <= '0;
      cnt   <= '0;
      wen   <= 1'b0;
      stat  <= 1'b0;
      rd_oe <= 1'b0;
      do_r  <= 1'b0;
    end else if (!cs) begin
      st    <= S_IDLE;
      rd_oe <= 1'b0;
      if (go) stat <= 1'b1;
    end else if (sck_rise) begin
      case (st)
        S_IDLE: if (di && !busy) begin
          st   <= S_CMD;
          cnt  <= '0;
          hdr  <= '0;
          stat <= 1'b0;
        end
        S_CMD: begin
          hdr <= nh[HW-2:0];
          cnt <= cnt + 1'b1;
          if (cnt == hlen - 5'd1) begin
            cnt <= '0;
            case (op_n)
              2'b10: begin
                rd_sr <= rdata;
                do_r  <= 1'b0;
                rd_oe <= 1'b1;
                st    <= S_RD;
              end
              2'b01: begin pend <= P_WR; st <= S_WDAT; end
              2'b11: begin pend <= P_ER; st <= S_ARM; end
              default: case (sub_n)
                2'b11:   begin wen <= 1'b1; st <= S_DONE; end
                2'b00:   begin wen <= 1'b0; st <= S_DONE; end
                2'b01:   begin pend <= P_WRAL; st <= S_WDAT; end
                default: begin pend <= P_ERAL; st <= S_ARM; end
              endcase
            endcase
          end
        end
        S_WDAT: begin
          dat <= {dat[14:0], di};
          cnt <= cnt + 1'b1;
          if (cnt == dlen - 5'd1) st <= S_ARM;
        end
        S_RD: begin
          if (cnt == dlen) begin
            rd_oe <= 1'b0;
            st    <= S_DONE;
          end else begin
            do_r  <= rd_sr[15];
            rd_sr <= {rd_sr[14:0], 1'b0};
            cnt   <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (go) begin
      case (pend)
        P_WR:
          if (org16) mem[w_held] <= dat;
          else if (a_held[0]) mem[w_held][15:8] <= dat[7:0];
          else mem[w_held][7:0] <= dat[7:0];
        P_ER:
          if (org16) mem[w_held] <= '1;
          else if (a_held[0]) mem[w_held][15:8] <= '1;
          else mem[w_held][7:0] <= '1;
        P_WRAL:
          for (int i = 0; i < WORDS; i++) mem[i] <= org16 ? dat : {dat[7:0], dat[7:0]};
        default:
          for (int i = 0; i < WORDS; i++) mem[i] <= '1;
      endcase
    end
  end
endmodule

// File: rtl/uwire_eeprom_chk.sv
module uwire_eeprom_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       do_o,
  input logic       do_oe,
  input logic       rd_oe,
  input logic       busy,
  input logic       wen,
  input logic [2:0] st
);
  // R10
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !cs |-> !do_oe);
  // R9
  busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> st == 3'd0);
  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> !$past(cs));
  // R3
  dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(rd_oe) |-> !do_o && do_oe);
  // R4
  wen_set_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(wen) |-> $past(st) == 3'd1);
  // R11
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n) !cs |=> st == 3'd0);
endmodule

bind uwire_eeprom uwire_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .do_o(do_o), .do_oe(do_oe),
  .rd_oe(rd_oe), .busy(busy), .wen(wen), .st(st)
);

// File: tb/sim_uwire_eeprom.sv
module sim_uwire_eeprom;
  localparam int CLK_P = 10;
  localparam int WC    = 60;

  logic clk = 0, rst_n = 0, org16 = 1, cs = 0, sck = 0, di = 0;
  logic do_o, do_oe;
  int   total = 0, fails = 0;
  logic [1:0] exp_q[$];
  string      tag_q[$];
  event       smp;

  uwire_eeprom #(.MEM_BITS(4096), .WRITE_CYCLES(WC)) u0 (
    .clk(clk), .rst_n(rst_n), .org16(org16), .cs(cs), .sck(sck), .di(di),
    .do_o(do_o), .do_oe(do_oe)
  );

  always #(CLK_P / 2) clk = ~clk;

  task automatic check(input string t, input logic [1:0] got, input logic [1:0] expv);
    total++;
    if (got !== expv) begin
      fails++;
      $display("FAIL %s: got oe/do=%b expected %b", t, got, expv);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always begin
    @(smp);
    check(tag_q.pop_front(), {do_oe, do_oe & do_o}, exp_q.pop_front());
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  task automatic expect_do(input logic oe, input logic v, input string t);
    exp_q.push_back({oe, oe & v});
    tag_q.push_back(t);
    -> smp;
    #1;
  endtask

  task automatic tick(input logic b);
    @(negedge clk); di = b; sck = 0;
    @(negedge clk); sck = 1;
    @(negedge clk);
  endtask

  task automatic csh;
    @(negedge clk); cs = 1; sck = 0;
    @(negedge clk);
  endtask

  task automatic csl;
    @(negedge clk); cs = 0; sck = 0; di = 0;
    repeat (2) @(negedge clk);
  endtask

  function automatic int aw();  return org16 ? 8 : 9;  endfunction
  function automatic int dw();  return org16 ? 16 : 8; endfunction

  task automatic send_hdr(input logic [1:0] op, input logic [8:0] a);
    tick(1'b1); tick(op[1]); tick(op[0]);
    for (int i = aw() - 1; i >= 0; i--) tick(a[i]);
  endtask

  task automatic rd(input logic [8:0] a, input logic [15:0] e, input int lead, input string t);
    csh;
    for (int i = 0; i < lead; i++) tick(1'b0);
    send_hdr(2'b10, a);
    expect_do(1, 0, {t, " dummy"});
    for (int i = dw() - 1; i >= 0; i--) begin
      tick(1'b0);
      expect_do(1, e[i], t);
    end
    tick(1'b0);
    expect_do(0, 0, {t, " release"});
    csl;
  endtask

  task automatic cmd(input logic [1:0] op, input logic [8:0] a, input int nd, input logic [15:0] d);
    csh;
    send_hdr(op, a);
    for (int i = dw() - 1; i >= dw() - nd; i--) tick(d[i]);
    csl;
  endtask

  task automatic wait_ready(input string t);
    csh;
    expect_do(1, 0, {t, " busy"});
    repeat (WC + 4) @(negedge clk);
    expect_do(1, 1, {t, " ready"});
    csl;
  endtask

  function automatic logic [8:0] sub(input logic [1:0] s);
    return org16 ? {1'b0, s, 6'd0} : {s, 7'd0};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_do(0, 0, "R10 reset tristate");
    rd(9'd5, 16'hFFFF, 0, "R10 R3 erased after reset");
    cmd(2'b01, 9'd5, 16, 16'h1234);
    csh; expect_do(0, 0, "R4 disabled write no status"); csl;
    rd(9'd5, 16'hFFFF, 0, "R4 disabled write ignored");
    cmd(2'b00, sub(2'b11), 0, 0);
    cmd(2'b01, 9'd5, 16, 16'hA5C3);
    wait_ready("R8 write");
    rd(9'd5, 16'hA5C3, 0, "R1 R3 word read");
    csh; tick(1'b1); tick(1'b1); tick(1'b0); tick(1'b0); tick(1'b1); csl;
    csh; expect_do(0, 0, "R11 aborted read silent"); csl;
    cmd(2'b01, 9'd5, 4, 16'h0000);
    csh; expect_do(0, 0, "R11 short write no busy"); csl;
    rd(9'd5, 16'hA5C3, 0, "R11 short write ignored");
    cmd(2'b11, 9'd5, 0, 0);
    wait_ready("R6 erase");
    rd(9'd5, 16'hFFFF, 2, "R6 R2 erased word with leading zeros");
    cmd(2'b00, sub(2'b01), 16, 16'h3C5A);
    wait_ready("R7 write-all");
    rd(9'd0, 16'h3C5A, 0, "R7 first word");
    rd(9'd255, 16'h3C5A, 0, "R7 last word");
    cmd(2'b01, 9'd9, 16, 16'h7E81);
    csh;
    send_hdr(2'b10, 9'd5);
    expect_do(1, 0, "R9 read ignored while busy");
    repeat (WC + 4) @(negedge clk);
    expect_do(1, 1, "R8 ready after busy");
    csl;
    rd(9'd9, 16'h7E81, 0, "R9 write landed");
    cmd(2'b00, sub(2'b00), 0, 0);
    cmd(2'b00, sub(2'b10), 0, 0);
    csh; expect_do(0, 0, "R4 erase-all after disable no status"); csl;
    rd(9'd0, 16'h3C5A, 0, "R4 erase-all ignored");
    org16 = 0;
    cmd(2'b00, sub(2'b11), 0, 0);
    cmd(2'b01, 9'd3, 8, 16'h0096);
    wait_ready("R5 byte write");
    rd(9'd3, 16'h0096, 0, "R5 R1 byte 3");
    rd(9'd2, 16'h005A, 0, "R5 byte 2 untouched");
    org16 = 1;
    rd(9'd1, 16'h965A, 0, "R5 word view of bytes");
    org16 = 0;
    cmd(2'b11, 9'd2, 0, 0);
    wait_ready("R6 byte erase");
    org16 = 1;
    rd(9'd1, 16'h96FF, 0, "R6 byte erase in word view");
    org16 = 0;
    cmd(2'b00, sub(2'b10), 0, 0);
    wait_ready("R6 erase-all");
    rd(9'd18, 16'h00FF, 0, "R6 erase-all byte");
    cmd(2'b00, sub(2'b01), 8, 16'h003C);
    wait_ready("R7 byte write-all");
    org16 = 1;
    rd(9'd0, 16'h3C3C, 0, "R7 byte fill in word view");
    total++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    summary();
  end
endmodule